// File: doc/BRIEF.md
# PWM Counter Event Interrupt and ADC Trigger Unit

This unit sits beside the counter of one PWM generator and turns counter activity into an interrupt request and an ADC start pulse. Each clock it compares the counter value against zero, against the load value, and against two compare values, A and B. The two compare matches are split by the counter's direction, which gives six distinct events. Two independent enable masks decide which events reach the interrupt line and which reach the ADC trigger. Any mix of events may be enabled on either path.

A sticky raw status register records every event as it happens, whatever the enables hold. Software clears a status bit by writing a one to it. The interrupt line is a level signal. It stays high while any enabled status bit is set. The ADC trigger is a one-clock pulse, and it carries no information about which event caused it. A small register port with address, write strobe, write data and combinational read data gives access to the enable and status registers. The counter, the waveform logic and the ADC are outside the unit and appear only as ports.

Top module: `pwm_evt_irq_unit`

## Requirements
- R1: Event bit 0 marks the counter reaching zero and event bit 1 marks the counter reaching the load value. Both are independent of direction.
- R2: Compare events are qualified by `cnt_up` (1 = counting up, 0 = counting down): bit 2 = match A while up, bit 3 = match A while down, bit 4 = match B while up, bit 5 = match B while down. Several events may fire in the same cycle.
- R3: The enable register is at address 0. Bits 5:0 are the interrupt enables and bits 13:8 are the trigger enables, both in the event bit order of R1 and R2. All other bits read as zero, and the register resets to zero.
- R4: The raw status register is at address 1, with bits 5:0 in event order. A bit sets on its event whether or not it is enabled, stays set, and resets to zero.
- R5: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. If a clear and a new event on the same bit fall in the same cycle, the bit stays set.
- R6: `irq_out` is high exactly while the status register ANDed with the interrupt enables is nonzero.
- R7: `adc_trig` is high for one clock, the cycle after any event whose trigger enable is set. It does not depend on the status register.
- R8: An event fires only in the first cycle the counter holds a matching value. A counter that holds its value produces no further events.
- R9: Addresses other than 0 and 1 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Current PWM counter value |
| cnt_up | input | 1 | Counter direction, 1 = up |
| load_val | input | CNT_W | Counter load value |
| cmp_a | input | CNT_W | Compare value A |
| cmp_b | input | CNT_W | Compare value B |
| reg_addr | input | ADDR_W | Register address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational on address |
| irq_out | output | 1 | Interrupt request level |
| adc_trig | output | 1 | One-clock ADC trigger pulse |

## Verification
Counter inputs that change before a clock edge produce a status bit and an ADC pulse that are both visible just after that edge. The pulse is gone after the following edge. The interrupt level follows the status and enable registers with no further delay, so it changes right after the edge that sets status or writes an enable. Read data is combinational and is checked a short delay after the address is set. The bench drives inputs one time unit after a rising edge and samples one time unit after the next rising edge. It reads status and the trigger at that point, and holds the counter steady while it clears status, so a stale event cannot mask a result.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

    localparam int NUM_EVT  = 6;
    localparam int IRQ_LSB  = 0;
    localparam int TRIG_LSB = 8;
    localparam int ADR_EN   = 0;
    localparam int ADR_ST   = 1;

    typedef enum int unsigned {
        EV_ZERO = 0,
        EV_LOAD = 1,
        EV_AUP  = 2,
        EV_ADN  = 3,
        EV_BUP  = 4,
        EV_BDN  = 5
    } evt_idx_e;

    typedef logic [NUM_EVT-1:0] evt_vec_t;

    typedef struct packed {
        evt_vec_t trig;
        evt_vec_t irq;
    } en_t;

    typedef struct packed {
        logic eq_zero;
        logic eq_load;
        logic eq_a;
        logic eq_b;
    } match_t;

    function automatic evt_vec_t build_evt(input match_t m, input logic up, input logic fresh);
        evt_vec_t v;
        v          = '0;
        v[EV_ZERO] = m.eq_zero;
        v[EV_LOAD] = m.eq_load;
        v[EV_AUP]  = m.eq_a &  up;
        v[EV_ADN]  = m.eq_a & ~up;
        v[EV_BUP]  = m.eq_b &  up;
        v[EV_BDN]  = m.eq_b & ~up;
        return fresh ? v : '0;
    endfunction

endpackage

// File: rtl/pwm_evt_detect.sv
module pwm_evt_detect
    import pwm_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_up,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    output evt_vec_t         evt
);

    logic [CNT_W-1:0] prev_cnt;
    logic             prev_valid;
    logic             fresh;
    match_t           m;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_cnt   <= '0;
            prev_valid <= 1'b0;
        end else begin
            prev_cnt   <= cnt_val;
            prev_valid <= 1'b1;
        end
    end

    always_comb begin
        fresh     = !prev_valid || (cnt_val != prev_cnt);
        m.eq_zero = (cnt_val == '0);
        m.eq_load = (cnt_val == load_val);
        m.eq_a    = (cnt_val == cmp_a);
        m.eq_b    = (cnt_val == cmp_b);
        evt       = build_evt(m, cnt_up, fresh);
    end

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (prev_valid && $stable(cnt_val)) |-> (evt == '0)); // R8
    AST_DIR_EXCL_A: assert property (@(posedge clk) disable iff (rst)
        !(evt[EV_AUP] && evt[EV_ADN])); // R2
    AST_DIR_EXCL_B: assert property (@(posedge clk) disable iff (rst)
        !(evt[EV_BUP] && evt[EV_BDN])); // R2

endmodule

// File: rtl/pwm_evt_regs.sv
module pwm_evt_regs
    import pwm_evt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  evt_vec_t          evt,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    output en_t               en,
    output evt_vec_t          status,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam int EN_MSB_IRQ  = IRQ_LSB + NUM_EVT - 1;
    localparam int EN_MSB_TRIG = TRIG_LSB + NUM_EVT - 1;

    logic     sel_en;
    logic     sel_st;
    evt_vec_t clr;

    assign sel_en = (reg_addr == ADDR_W'(ADR_EN));
    assign sel_st = (reg_addr == ADDR_W'(ADR_ST));
    assign clr    = (reg_wen && sel_st) ? reg_wdata[NUM_EVT-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en <= '0;
        end else if (reg_wen && sel_en) begin
            en.irq  <= reg_wdata[EN_MSB_IRQ:IRQ_LSB];
            en.trig <= reg_wdata[EN_MSB_TRIG:TRIG_LSB];
        end
    end

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_st
        always_ff @(posedge clk) begin
            if (rst) begin
                status[i] <= 1'b0;
            end else if (evt[i]) begin
                status[i] <= 1'b1;
            end else if (clr[i]) begin
                status[i] <= 1'b0;
            end
        end

        AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
            evt[i] |=> status[i]); // R5
        AST_STICKY: assert property (@(posedge clk) disable iff (rst)
            (status[i] && !clr[i]) |=> status[i]); // R4
    end

    always_comb begin
        reg_rdata = '0;
        if (sel_en) begin
            reg_rdata[EN_MSB_IRQ:IRQ_LSB]   = en.irq;
            reg_rdata[EN_MSB_TRIG:TRIG_LSB] = en.trig;
        end else if (sel_st) begin
            reg_rdata[NUM_EVT-1:0] = status;
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        sel_en |-> (reg_rdata[DATA_W-1:EN_MSB_TRIG+1] == '0)); // R3
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!sel_en && !sel_st) |-> (reg_rdata == '0)); // R9

endmodule

// File: rtl/pwm_evt_route.sv
module pwm_evt_route
    import pwm_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_vec_t evt,
    input  en_t      en,
    input  evt_vec_t status,
    output logic     irq_out,
    output logic     adc_trig
);

    always_ff @(posedge clk) begin
        if (rst) begin
            adc_trig <= 1'b0;
        end else begin
            adc_trig <= |(evt & en.trig);
        end
    end

    assign irq_out = |(status & en.irq);

    AST_TRIG_CAUSE: assert property (@(posedge clk) disable iff (rst)
        adc_trig |-> $past(|(evt & en.trig))); // R7
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (status != '0)); // R6

endmodule

// File: rtl/pwm_evt_irq_unit.sv
module pwm_evt_irq_unit
    import pwm_evt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              cnt_up,
    input  logic [CNT_W-1:0]  load_val,
    input  logic [CNT_W-1:0]  cmp_a,
    input  logic [CNT_W-1:0]  cmp_b,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out,
    output logic              adc_trig
);

    evt_vec_t evt;
    evt_vec_t status;
    en_t      en;

    pwm_evt_detect #(.CNT_W(CNT_W)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .cnt_val  (cnt_val),
        .cnt_up   (cnt_up),
        .load_val (load_val),
        .cmp_a    (cmp_a),
        .cmp_b    (cmp_b),
        .evt      (evt)
    );

    pwm_evt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .en        (en),
        .status    (status),
        .reg_rdata (reg_rdata)
    );

    pwm_evt_route u_route (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .en       (en),
        .status   (status),
        .irq_out  (irq_out),
        .adc_trig (adc_trig)
    );

endmodule

// File: tb/pwm_evt_irq_unit_test.sv
module pwm_evt_irq_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cnt_val, load_val, cmp_a, cmp_b;
    logic        cnt_up;
    logic [1:0]  reg_addr;
    logic        reg_wen;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_out, adc_trig;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pwm_evt_irq_unit uut (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_up(cnt_up),
        .load_val(load_val), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out), .adc_trig(adc_trig)
    );

    typedef struct packed {
        logic [15:0] c;
        logic        up;
        logic [15:0] ld;
        logic [15:0] a;
        logic [15:0] b;
        logic [5:0]  ex;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'd0,   1'b1, 16'd100, 16'd40, 16'd70, 6'h01},
        '{16'd100, 1'b1, 16'd100, 16'd40, 16'd70, 6'h02},
        '{16'd40,  1'b1, 16'd100, 16'd40, 16'd70, 6'h04},
        '{16'd70,  1'b1, 16'd100, 16'd40, 16'd70, 6'h10},
        '{16'd40,  1'b0, 16'd100, 16'd40, 16'd70, 6'h08},
        '{16'd70,  1'b0, 16'd100, 16'd40, 16'd70, 6'h20},
        '{16'd55,  1'b1, 16'd100, 16'd40, 16'd70, 6'h00},
        '{16'd25,  1'b1, 16'd25,  16'd25, 16'd25, 6'h16},
        '{16'd0,   1'b0, 16'd100, 16'd0,  16'd70, 6'h09},
        '{16'd70,  1'b0, 16'd70,  16'd40, 16'd70, 6'h22}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wen   = 1'b1;
        tick();
        reg_wen   = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; cnt_val = 16'd7; cnt_up = 1'b1;
        load_val = 16'd100; cmp_a = 16'd40; cmp_b = 16'd70;
        reg_addr = 2'd0; reg_wen = 1'b0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        // reset state
        chk("R3 reset irq", {31'b0, irq_out}, 32'd0);
        chk("R7 reset trig", {31'b0, adc_trig}, 32'd0);
        rd_chk("R3 enable reset", 2'd0, 32'h0);
        rd_chk("R4 status reset", 2'd1, 32'h0);
        rst = 1'b0;
        tick();

        // R3 enable field layout and reserved bits
        wr(2'd0, 32'hFFFF_FFFF);
        rd_chk("R3 enable mask", 2'd0, 32'h0000_3F3F);
        // R9 unmapped addresses
        wr(2'd2, 32'h0);
        wr(2'd3, 32'h0);
        rd_chk("R9 write ignored", 2'd0, 32'h0000_3F3F);
        rd_chk("R9 read addr2", 2'd2, 32'h0);
        rd_chk("R9 read addr3", 2'd3, 32'h0);

        // vector table: R1 R2 events, R7 pulse, R6 level
        for (int i = 0; i < NV; i++) begin
            cnt_val  = VECS[i].c;
            cnt_up   = VECS[i].up;
            load_val = VECS[i].ld;
            cmp_a    = VECS[i].a;
            cmp_b    = VECS[i].b;
            tick();
            rd_chk("R1 R2 status vector", 2'd1, {26'b0, VECS[i].ex});
            chk("R7 trig vector", {31'b0, adc_trig}, {31'b0, VECS[i].ex != 6'h0});
            chk("R6 irq vector", {31'b0, irq_out}, {31'b0, VECS[i].ex != 6'h0});
            wr(2'd1, 32'h3F);
            rd_chk("R5 clear vector", 2'd1, 32'h0);
            chk("R7 single pulse", {31'b0, adc_trig}, 32'd0);
        end

        // R4 status sets with all enables off
        load_val = 16'd100; cmp_a = 16'd40; cmp_b = 16'd70; cnt_up = 1'b1;
        wr(2'd0, 32'h0);
        cnt_val = 16'd0;
        tick();
        rd_chk("R4 status without enable", 2'd1, 32'h01);
        chk("R7 no trig when disabled", {31'b0, adc_trig}, 32'd0);
        chk("R6 no irq when disabled", {31'b0, irq_out}, 32'd0);

        // R6 irq follows enable on existing status
        wr(2'd0, 32'h01);
        chk("R6 irq on enable", {31'b0, irq_out}, 32'd1);
        wr(2'd0, 32'h02);
        chk("R6 irq other enable", {31'b0, irq_out}, 32'd0);

        // R5 write-zero and selective clear
        wr(2'd1, 32'h00);
        rd_chk("R5 write zero keeps", 2'd1, 32'h01);
        wr(2'd1, 32'h3E);
        rd_chk("R5 other bits keep", 2'd1, 32'h01);
        wr(2'd1, 32'h01);
        rd_chk("R5 clear bit", 2'd1, 32'h00);

        // R5 event wins over same-cycle clear
        cnt_val = 16'd100;
        wr(2'd1, 32'h02);
        rd_chk("R5 event wins", 2'd1, 32'h02);
        chk("R6 irq load enabled", {31'b0, irq_out}, 32'd1);

        // R8 holding counter gives no new events
        wr(2'd1, 32'h3F);
        tick(); tick(); tick();
        rd_chk("R8 hold no event", 2'd1, 32'h00);
        chk("R8 irq stays low", {31'b0, irq_out}, 32'd0);

        // R7 trigger pulse width, independent of status
        wr(2'd0, 32'h0100);
        cnt_val = 16'd5;
        tick();
        chk("R7 no trig off match", {31'b0, adc_trig}, 32'd0);
        cnt_val = 16'd0;
        tick();
        chk("R7 trig pulse", {31'b0, adc_trig}, 32'd1);
        tick();
        chk("R7 trig ends", {31'b0, adc_trig}, 32'd0);
        cnt_val = 16'd100;
        tick();
        chk("R7 trig masked event", {31'b0, adc_trig}, 32'd0);

        finish_run();
    end

endmodule